// File: doc/BRIEF.md
# Serial NOR Flash Write-Protection Gate

This block sits in the command path of a serial NOR flash controller. It decides whether a command that changes stored data or the status register may run. After the serial front end finishes a frame, it presents the opcode, the 21-bit target address, the number of clock edges counted while chip select was active, and the current protection fields of the status register. It also presents the level of the active-low write-protect pin. One cycle later the gate gives a completion strobe with exactly one of two verdicts: execute or reject.

The gate owns the write-enable latch. A program, erase or status-register write needs this latch to be set. The latch clears when such a command is accepted. The block-protect field reserves a region at the top of the 2 MB array. The region grows by powers of two sectors, and its largest settings cover the whole array. A frame whose edge count is not a whole number of bytes is discarded. The array itself, program and erase timing, and serial shifting are handled elsewhere.

Top module: `wp_gate`

## Requirements
- R1: One cycle after a clock edge with `cmd_valid_i` high, `done_o` pulses for one cycle with exactly one of `exec_o` and `reject_o` high. When no command was presented, all three are low.
- R2: Opcode 06h always executes and sets `wel_o`. Opcode 04h always executes and clears `wel_o`. The edge count is ignored for both.
- R3: Asynchronous reset clears `wel_o` and all decision outputs.
- R4: Page program (02h), sector erase (D8h), bulk erase (C7h) and status write (01h) are rejected when `wel_o` is low.
- R5: Those four commands are rejected when the low three bits of `edge_cnt_i` are not all zero.
- R6: With protection field value k from 1 to 5, sectors `addr_i[20:16]` ≥ 32 − 2^(k−1) are protected. Value 0 protects none. Program or erase of a protected sector is rejected.
- R7: Protection field values 6 and 7 protect every sector.
- R8: Bulk erase is rejected whenever the protection field is non-zero.
- R9: Status write is rejected when `srwd_i` is 1 and `wp_n_i` is 0. In every other case it is subject only to R4 and R5.
- R10: An accepted program, erase or status write clears `wel_o`. A rejected command leaves `wel_o` unchanged.
- R11: Any other opcode is rejected and leaves `wel_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Frame-finished strobe |
| cmd_op_i | input | 8 | Opcode of the frame |
| addr_i | input | 21 | Target byte address |
| edge_cnt_i | input | 16 | Clock edges counted in the frame |
| bp_i | input | 3 | Block-protect field |
| srwd_i | input | 1 | Status-register write-disable bit |
| wp_n_i | input | 1 | Write-protect pin, active low |
| done_o | output | 1 | Decision strobe |
| exec_o | output | 1 | Command may run |
| reject_o | output | 1 | Command discarded |
| wel_o | output | 1 | Write-enable latch |

## Verification
The hardest case to reach is a modifying command where every gate except one is open. In that case the latch is set, the count is aligned, and the command falls exactly on a protection boundary sector or meets the status-register lock. Uniform random stimulus seldom reaches it, because each earlier command can clear the latch. The stimulus therefore issues a write-enable before most random commands, keeps most edge counts aligned, and biases addresses toward the sectors around each boundary. Directed sequences then cover each boundary value and each lock combination.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_WRSR = 8'h01;

  function automatic logic is_modify(logic [7:0] op);
    return (op == OP_PP) || (op == OP_SE) || (op == OP_BE) || (op == OP_WRSR);
  endfunction
endpackage

// File: rtl/wp_prot_decode.sv
module wp_prot_decode #(
  parameter int SECT_W = 5,
  parameter int BP_W   = 3
) (
  input  logic [SECT_W-1:0] sect_i,
  input  logic [BP_W-1:0]   bp_i,
  output logic              prot_o
);
  localparam int LEVELS = 1 << BP_W;

  // top_q[g]: sector lies in the top 2^g sectors
  logic [LEVELS-1:0] top_q;
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    if (g < SECT_W) begin : g_part
      assign top_q[g] = &sect_i[SECT_W-1:g];
    end else begin : g_all
      assign top_q[g] = 1'b1;
    end
  end

  logic [BP_W-1:0] lvl;
  assign lvl    = bp_i - BP_W'(1);
  assign prot_o = (bp_i != '0) && top_q[lvl];
endmodule

// File: rtl/wp_policy.sv
module wp_policy
  import wp_gate_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic       wel_i,
  input  logic       aligned_i,
  input  logic       prot_i,
  input  logic       bp_any_i,
  input  logic       srwd_i,
  input  logic       wp_n_i,
  output logic       exec_o,
  output logic       set_wel_o,
  output logic       clr_wel_o
);
  logic gate_ok;
  assign gate_ok = wel_i & aligned_i;

  always_comb begin
    exec_o    = 1'b0;
    set_wel_o = 1'b0;
    clr_wel_o = 1'b0;
    unique case (op_i)
      OP_WREN: begin exec_o = 1'b1; set_wel_o = 1'b1; end
      OP_WRDI: begin exec_o = 1'b1; clr_wel_o = 1'b1; end
      OP_PP, OP_SE: exec_o = gate_ok & ~prot_i;
      OP_BE:        exec_o = gate_ok & ~bp_any_i;
      OP_WRSR:      exec_o = gate_ok & ~(srwd_i & ~wp_n_i);
      default:      exec_o = 1'b0;
    endcase
    if (is_modify(op_i)) clr_wel_o = exec_o;
  end
endmodule

// File: rtl/wp_wel_latch.sv
module wp_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
    else if (clr_i) wel_o <= 1'b0;
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5,
  parameter int CNT_W  = 16,
  parameter int BP_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  edge_cnt_i,
  input  logic [BP_W-1:0]   bp_i,
  input  logic              srwd_i,
  input  logic              wp_n_i,
  output logic              done_o,
  output logic              exec_o,
  output logic              reject_o,
  output logic              wel_o
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic unused_bits;
  assign unused_bits = ^{addr_i[SECT_LSB-1:0], edge_cnt_i[CNT_W-1:3]};

  logic prot, aligned, dec_exec, set_wel, clr_wel;
  assign aligned = (edge_cnt_i[2:0] == 3'b000);

  wp_prot_decode #(.SECT_W(SECT_W), .BP_W(BP_W)) u_prot (
    .sect_i (addr_i[ADDR_W-1:SECT_LSB]),
    .bp_i   (bp_i),
    .prot_o (prot)
  );

  wp_policy u_policy (
    .op_i      (cmd_op_i),
    .wel_i     (wel_o),
    .aligned_i (aligned),
    .prot_i    (prot),
    .bp_any_i  (bp_i != '0),
    .srwd_i    (srwd_i),
    .wp_n_i    (wp_n_i),
    .exec_o    (dec_exec),
    .set_wel_o (set_wel),
    .clr_wel_o (clr_wel)
  );

  wp_wel_latch u_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cmd_valid_i & set_wel),
    .clr_i  (cmd_valid_i & clr_wel),
    .wel_o  (wel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      exec_o   <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      done_o   <= cmd_valid_i;
      exec_o   <= cmd_valid_i & dec_exec;
      reject_o <= cmd_valid_i & ~dec_exec;
    end
  end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk
  import wp_gate_pkg::*;
#(
  parameter int BP_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic [7:0]      cmd_op_i,
  input logic [2:0]      cnt_lsb_i,
  input logic [BP_W-1:0] bp_i,
  input logic            srwd_i,
  input logic            wp_n_i,
  input logic            done_o,
  input logic            exec_o,
  input logic            reject_o,
  input logic            wel_o
);
  logic mod_cmd, known_cmd;
  assign mod_cmd   = cmd_valid_i && is_modify(cmd_op_i);
  assign known_cmd = mod_cmd || cmd_op_i == OP_WREN || cmd_op_i == OP_WRDI;

  assert_done_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!done_o && !exec_o && !reject_o));
  assert_one_verdict_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({exec_o, reject_o}));
  assert_wren_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_WREN) |=> (wel_o && exec_o));
  assert_wrdi_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_WRDI) |=> (!wel_o && exec_o));
  assert_need_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_cmd && !wel_o) |=> reject_o);
  assert_byte_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_cmd && cnt_lsb_i != 3'b000) |=> reject_o);
  assert_full_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == OP_PP || cmd_op_i == OP_SE) && bp_i >= 3'd6) |=> reject_o);
  assert_bulk_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_BE && bp_i != '0) |=> reject_o);
  assert_srwd_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_WRSR && srwd_i && !wp_n_i) |=> reject_o);
  assert_wel_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_cmd |=> ((!exec_o || !wel_o) && (!reject_o || wel_o == $past(wel_o))));
  assert_unknown_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !known_cmd) |=> (reject_o && $stable(wel_o)));
endmodule

bind wp_gate wp_gate_chk #(.BP_W(BP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cnt_lsb_i   (edge_cnt_i[2:0]),
  .bp_i        (bp_i),
  .srwd_i      (srwd_i),
  .wp_n_i      (wp_n_i),
  .done_o      (done_o),
  .exec_o      (exec_o),
  .reject_o    (reject_o),
  .wel_o       (wel_o)
);

// File: tb/tb_wp_gate.sv
`timescale 1ns/1ps
module tb_wp_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  op = '0;
  logic [20:0] addr = '0;
  logic [15:0] cnt = '0;
  logic [2:0]  bp = '0;
  logic        srwd = 1'b0, wpn = 1'b1;
  logic        done, ex, rej, wel;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  bit m_wel = 0;

  always #2.5 clk = ~clk;

  wp_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .addr_i(addr), .edge_cnt_i(cnt), .bp_i(bp), .srwd_i(srwd), .wp_n_i(wpn),
    .done_o(done), .exec_o(ex), .reject_o(rej), .wel_o(wel)
  );

  function automatic bit prot_ref(logic [2:0] b, logic [20:0] a);
    int s = int'(a[20:16]);
    if (b == 0) return 0;
    if (b >= 6) return 1;
    return s >= 32 - (1 << (int'(b) - 1));
  endfunction

  // expected verdict and the requirement that decides it
  function automatic bit exp_exec(logic [7:0] o, logic [20:0] a, logic [15:0] c,
                                  logic [2:0] b, logic s, logic w, bit lw,
                                  output string tag);
    bit is_mod = (o == 8'h02 || o == 8'hD8 || o == 8'hC7 || o == 8'h01);
    if (o == 8'h06 || o == 8'h04) begin tag = "R2"; return 1; end
    if (!is_mod)                  begin tag = "R11"; return 0; end
    if (!lw)                      begin tag = "R4"; return 0; end
    if (c[2:0] != 0)              begin tag = "R5"; return 0; end
    if (o == 8'hC7 && b != 0)     begin tag = "R8"; return 0; end
    if ((o == 8'h02 || o == 8'hD8) && b >= 6) begin tag = "R7"; return 0; end
    if ((o == 8'h02 || o == 8'hD8) && prot_ref(b, a)) begin tag = "R6"; return 0; end
    if (o == 8'h01 && s && !w)    begin tag = "R9"; return 0; end
    tag = "R10";
    return 1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [7:0] o, logic [20:0] a, logic [15:0] c,
                       logic [2:0] b, logic s, logic w);
    string tag;
    bit e, nw;
    @(negedge clk);
    op = o; addr = a; cnt = c; bp = b; srwd = s; wpn = w; valid = 1'b1;
    e = exp_exec(o, a, c, b, s, w, m_wel, tag);
    nw = m_wel;
    if (o == 8'h06) nw = 1;
    else if (o == 8'h04) nw = 0;
    else if (e) nw = 0;
    @(negedge clk);
    valid = 1'b0;
    chk("R1", "done", done, 1);
    chk(tag, "exec", ex, e);
    chk(tag, "reject", rej, !e);
    chk(tag == "R2" ? "R2" : "R10", "wel", wel, nw);
    m_wel = nw;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m_wel = 0;
    chk("R3", "wel", wel, 0);
    chk("R3", "done", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R3", "wel", wel, 0);
    chk("R3", "exec", ex, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle done", done, 0);

    // R4: no latch
    issue(8'h02, 21'h000100, 16'd40, 3'd0, 0, 1);
    // R6 boundaries for each field value
    for (int k = 1; k <= 5; k++) begin
      int lo = 32 - (1 << (k - 1));
      issue(8'h06, 0, 16'd8, 0, 0, 1);
      issue(8'h02, 21'(lo) << 16, 16'd2080, 3'(k), 0, 1);  // R6 first protected
      issue(8'hD8, 21'(lo - 1) << 16, 16'd32, 3'(k), 0, 1); // R6 just below, runs
    end
    // R7 full lock
    issue(8'h06, 0, 16'd8, 0, 0, 1);
    issue(8'h02, 21'h000000, 16'd40, 3'd6, 0, 1);
    issue(8'hD8, 21'h000000, 16'd32, 3'd7, 0, 1);
    // R5 misaligned then aligned
    issue(8'hD8, 21'h010000, 16'd31, 3'd0, 0, 1);
    issue(8'hD8, 21'h010000, 16'd32, 3'd0, 0, 1);
    // R8 bulk
    issue(8'h06, 0, 16'd7, 0, 0, 1);
    issue(8'hC7, 0, 16'd8, 3'd1, 0, 1);
    issue(8'hC7, 0, 16'd8, 3'd0, 0, 1);
    // R9 status lock combos
    issue(8'h06, 0, 16'd8, 0, 0, 1);
    issue(8'h01, 0, 16'd16, 0, 1, 0);
    issue(8'h01, 0, 16'd16, 0, 1, 1);
    issue(8'h06, 0, 16'd8, 0, 0, 1);
    issue(8'h01, 0, 16'd16, 0, 0, 0);
    // R11 unknown with latch set, R2 disable
    issue(8'h06, 0, 16'd8, 0, 0, 1);
    issue(8'h03, 0, 16'd32, 0, 0, 1);
    issue(8'h04, 0, 16'd5, 0, 0, 1);
    // R3 reset with latch set
    issue(8'h06, 0, 16'd8, 0, 0, 1);
    do_reset();

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ops [7] = '{8'h06, 8'h04, 8'h02, 8'hD8, 8'hC7, 8'h01, 8'h0B};
      logic [20:0] a = 21'($urandom);
      logic [15:0] c = ($urandom % 8 == 0) ? 16'($urandom % 64) : 16'(($urandom % 300) * 8);
      logic [7:0] o = ops[$urandom % 7];
      if ($urandom % 2) a[20:16] = 5'(31 - ($urandom % 18));
      if ($urandom % 4 != 0) issue(8'h06, 0, 16'd8, 3'($urandom), 1'($urandom), 1'($urandom));
      issue(o, a, c, 3'($urandom), 1'($urandom), 1'($urandom));
      if (i % 500 == 499) do_reset();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule